// File: doc/BRIEF.md
# Looping Output Pattern Sequencer

This block plays a prepared timetable of 32-bit output words onto a latched output port. Software (or any loader) first fills two on-chip tables while the block is idle: a step table, where each entry pairs a microsecond time with an output word, and a block table, where each entry gives a segment length in steps and a repeat count. Segments lie back to back in the step table: the first block entry owns the first steps, the next entry owns the steps that follow, and so on. Nothing is driven until a separate go pulse arrives.

On go, the block walks the block table in order. Each pass through a segment measures time from the start of that pass. A microsecond counter is compared with the current step's time, and when the time has been reached the step's word is copied into the output latch, where it stays until another step replaces it. A segment is played as many times as its repeat count says; a count of zero, or a length of zero, passes the segment over. When the last pass of the last block has finished, a done flag rises and the final word remains on the output.

Time is kept on a microsecond grid of `TICKS_PER_US` clocks that is anchored to the go pulse, and at most one step is taken on each grid slot, so no output bit can change twice within one microsecond.

Top module: `seq_pattern_player`

## Requirements
- R1: During and right after reset, `pattern_out` is all zeros and `done` is low.
- R2: Table writes and the passing of time while idle never change `pattern_out`; it changes only as the result of a step taken during playback started by `go`.
- R3: Microsecond slot boundaries fall on the clock two cycles after the edge that samples `go`, then every `TICKS_PER_US` clocks. A pass starts on a boundary with elapsed time 0, and elapsed time rises by one on each later boundary. At a boundary where elapsed time is greater than or equal to the current step's time, that step's word appears on `pattern_out` one clock later.
- R4: At most one step is taken per slot: steps whose times are equal or already past are taken on successive boundaries, so `pattern_out` never changes twice within `TICKS_PER_US` clocks.
- R5: A block with repeat count N plays its segment N times; each new pass starts at the boundary after the slot of the previous pass's last step, with elapsed time back at 0.
- R6: Block entries are read in table order starting at index 0; each segment starts right after the previous entry's segment. An entry with repeat count 0 or length 0 is passed over in one clock, but its length still advances the segment start. A block entered from the scan starts its first pass on the first boundary after it is examined.
- R7: After the last of `blk_count` blocks, `done` goes high one clock after the scan reaches the end and stays high with `pattern_out` unchanged until the next `go`; that `go` clears `done` on the next clock. With `blk_count` 0, `done` is high two clocks after the `go` edge.
- R8: Writes to either table and further `go` pulses while playback runs are ignored: the running sequence and a later replay of the same tables are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start playback (accepted only while idle or done) |
| blk_count | input | 5 | Number of block entries to play, sampled with `go` |
| step_we | input | 1 | Step table write strobe |
| step_addr | input | 6 | Step table write index |
| step_time | input | 20 | Step time in microseconds relative to pass start |
| step_pattern | input | 32 | Step output word |
| blk_we | input | 1 | Block table write strobe |
| blk_addr | input | 4 | Block table write index |
| blk_len | input | 7 | Segment length in steps |
| blk_reps | input | 16 | Segment repeat count |
| pattern_out | output | 32 | Latched output word |
| done | output | 1 | Playback finished |

## Verification
The interesting collision is a table write, or a fresh `go`, landing in the same clock as a step being fetched and fired from that same table during playback. The bench provokes it by striking both tables at index 0, together with a `go` pulse, while the sequence is mid-run, and then replaying the sequence. Both the running sequence and the replay are compared on every clock against an event timeline computed in the bench from the tables it wrote, so any write that slipped through would shift a word or a time in one of the two runs.

// File: rtl/seqp_pkg.sv
package seqp_pkg;

    localparam int OUT_W   = 32;
    localparam int TIME_W  = 20;
    localparam int STEP_AW = 6;
    localparam int BLK_AW  = 4;
    localparam int REP_W   = 16;

    localparam int LEN_W   = STEP_AW + 1;
    localparam int BCNT_W  = BLK_AW + 1;

    typedef struct packed {
        logic [TIME_W-1:0] at_us;
        logic [OUT_W-1:0]  bits;
    } step_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [REP_W-1:0] reps;
    } blk_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RUN,
        ST_DONE
    } seq_st_t;

    function automatic logic blk_is_empty(blk_t b);
        return (b.len == '0) || (b.reps == '0);
    endfunction

endpackage

// File: rtl/seqp_table.sv
module seqp_table #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/seqp_us_timer.sv
module seqp_us_timer #(
    parameter int TICKS  = 125,
    parameter int TIME_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync,
    input  logic              clr_us,
    output logic              boundary,
    output logic              wrap,
    output logic [TIME_W-1:0] us
);
    localparam int PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS - 1);

    logic [PRE_W-1:0] pre;

    assign boundary = (pre == '0);
    assign wrap     = (pre == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
        end else if (sync) begin
            pre <= PRE_LAST;
        end else if (wrap) begin
            pre <= '0;
        end else begin
            pre <= pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            us <= '0;
        end else if (clr_us) begin
            us <= '0;
        end else if (wrap && (us != '1)) begin
            us <= us + TIME_W'(1);
        end
    end

endmodule

// File: rtl/seqp_ctrl.sv
module seqp_ctrl
    import seqp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [BCNT_W-1:0]  blk_count,
    input  logic               boundary,
    input  logic               wrap,
    input  logic [TIME_W-1:0]  us,
    input  step_t              cur_step,
    input  blk_t               cur_blk,
    output logic [STEP_AW-1:0] step_raddr,
    output logic [BLK_AW-1:0]  blk_raddr,
    output logic               fire,
    output logic               tmr_sync,
    output logic               us_clr,
    output logic               idle,
    output logic               in_run,
    output logic               in_scan,
    output logic               done
);
    seq_st_t            st;
    logic [BCNT_W-1:0]  blk_idx;
    logic [BCNT_W-1:0]  cnt_q;
    logic [STEP_AW-1:0] base;
    logic [LEN_W-1:0]   ptr;
    logic [REP_W-1:0]   rep_left;
    logic               again;
    logic               at_end;
    logic               empty;
    logic               last;

    always_comb begin
        idle       = (st == ST_IDLE) || (st == ST_DONE);
        in_run     = (st == ST_RUN);
        in_scan    = (st == ST_SCAN);
        at_end     = (blk_idx >= cnt_q);
        empty      = blk_is_empty(cur_blk);
        tmr_sync   = idle && go;
        us_clr     = in_scan && wrap && (again || (!at_end && !empty));
        fire       = in_run && boundary && (us >= cur_step.at_us);
        last       = (ptr == (cur_blk.len - LEN_W'(1)));
        step_raddr = base + STEP_AW'(ptr);
        blk_raddr  = blk_idx[BLK_AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            blk_idx  <= '0;
            cnt_q    <= '0;
            base     <= '0;
            ptr      <= '0;
            rep_left <= '0;
            again    <= 1'b0;
            done     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (go) begin
                        st      <= ST_SCAN;
                        blk_idx <= '0;
                        cnt_q   <= blk_count;
                        base    <= '0;
                        again   <= 1'b0;
                        done    <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (again) begin
                        if (wrap) begin
                            st    <= ST_RUN;
                            ptr   <= '0;
                            again <= 1'b0;
                        end
                    end else if (at_end) begin
                        st   <= ST_DONE;
                        done <= 1'b1;
                    end else if (empty) begin
                        base    <= base + STEP_AW'(cur_blk.len);
                        blk_idx <= blk_idx + BCNT_W'(1);
                    end else if (wrap) begin
                        st       <= ST_RUN;
                        ptr      <= '0;
                        rep_left <= cur_blk.reps;
                    end
                end
                ST_RUN: begin
                    if (fire) begin
                        if (last) begin
                            st <= ST_SCAN;
                            if (rep_left == REP_W'(1)) begin
                                base    <= base + STEP_AW'(cur_blk.len);
                                blk_idx <= blk_idx + BCNT_W'(1);
                            end else begin
                                rep_left <= rep_left - REP_W'(1);
                                again    <= 1'b1;
                            end
                        end else begin
                            ptr <= ptr + LEN_W'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seq_pattern_player.sv
module seq_pattern_player
    import seqp_pkg::*;
#(
    parameter int TICKS_PER_US = 125
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [BCNT_W-1:0]  blk_count,
    input  logic               step_we,
    input  logic [STEP_AW-1:0] step_addr,
    input  logic [TIME_W-1:0]  step_time,
    input  logic [OUT_W-1:0]   step_pattern,
    input  logic               blk_we,
    input  logic [BLK_AW-1:0]  blk_addr,
    input  logic [LEN_W-1:0]   blk_len,
    input  logic [REP_W-1:0]   blk_reps,
    output logic [OUT_W-1:0]   pattern_out,
    output logic               done
);
    localparam int STEP_W = $bits(step_t);
    localparam int BLK_W  = $bits(blk_t);

    logic [STEP_W-1:0]  step_rd;
    logic [BLK_W-1:0]   blk_rd;
    step_t              cur_step;
    blk_t               cur_blk;
    logic [STEP_AW-1:0] step_raddr;
    logic [BLK_AW-1:0]  blk_raddr;
    logic               fire;
    logic               tmr_sync;
    logic               us_clr;
    logic               idle;
    logic               in_run;
    logic               in_scan;
    logic               boundary;
    logic               wrap;
    logic [TIME_W-1:0]  us;

    assign cur_step = step_t'(step_rd);
    assign cur_blk  = blk_t'(blk_rd);

    seqp_table #(.W(STEP_W), .AW(STEP_AW)) u_steps (
        .clk   (clk),
        .we    (step_we && idle),
        .waddr (step_addr),
        .wdata ({step_time, step_pattern}),
        .raddr (step_raddr),
        .rdata (step_rd)
    );

    seqp_table #(.W(BLK_W), .AW(BLK_AW)) u_blocks (
        .clk   (clk),
        .we    (blk_we && idle),
        .waddr (blk_addr),
        .wdata ({blk_len, blk_reps}),
        .raddr (blk_raddr),
        .rdata (blk_rd)
    );

    seqp_us_timer #(.TICKS(TICKS_PER_US), .TIME_W(TIME_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .sync     (tmr_sync),
        .clr_us   (us_clr),
        .boundary (boundary),
        .wrap     (wrap),
        .us       (us)
    );

    seqp_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .blk_count  (blk_count),
        .boundary   (boundary),
        .wrap       (wrap),
        .us         (us),
        .cur_step   (cur_step),
        .cur_blk    (cur_blk),
        .step_raddr (step_raddr),
        .blk_raddr  (blk_raddr),
        .fire       (fire),
        .tmr_sync   (tmr_sync),
        .us_clr     (us_clr),
        .idle       (idle),
        .in_run     (in_run),
        .in_scan    (in_scan),
        .done       (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pattern_out <= '0;
        end else if (fire) begin
            pattern_out <= cur_step.bits;
        end
    end

endmodule

// File: rtl/seqp_chk.sv
module seqp_chk
    import seqp_pkg::*;
#(
    parameter int TICKS = 125
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic [OUT_W-1:0] pattern_out,
    input logic             done,
    input logic             in_run,
    input logic             in_scan
);
    logic [OUT_W-1:0] prev_pat;
    logic             prev_run;
    int               since;
    logic             chg;

    assign chg = (pattern_out != prev_pat);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pat <= '0;
            prev_run <= 1'b0;
            since    <= TICKS;
        end else begin
            prev_pat <= pattern_out;
            prev_run <= in_run;
            if (chg) begin
                since <= 1;
            end else if (since < TICKS) begin
                since <= since + 1;
            end
        end
    end

    assert_one_change_per_us_R4: assert property (@(posedge clk) disable iff (rst)
        chg |-> (since >= TICKS));

    assert_change_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
        chg |-> prev_run);

    assert_no_done_in_run_R5: assert property (@(posedge clk) disable iff (rst)
        in_run |-> !done);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !go) |=> done);

    assert_done_holds_word_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(pattern_out));

    assert_done_after_scan_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(in_scan));

endmodule

bind seq_pattern_player seqp_chk #(.TICKS(TICKS_PER_US)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .pattern_out (pattern_out),
    .done        (done),
    .in_run      (in_run),
    .in_scan     (in_scan)
);

// File: tb/seq_pattern_player_tb.sv
module seq_pattern_player_tb;
    import seqp_pkg::*;

    localparam int T = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               go = 1'b0;
    logic [BCNT_W-1:0]  blk_count = '0;
    logic               step_we = 1'b0;
    logic [STEP_AW-1:0] step_addr = '0;
    logic [TIME_W-1:0]  step_time = '0;
    logic [OUT_W-1:0]   step_pattern = '0;
    logic               blk_we = 1'b0;
    logic [BLK_AW-1:0]  blk_addr = '0;
    logic [LEN_W-1:0]   blk_len = '0;
    logic [REP_W-1:0]   blk_reps = '0;
    logic [OUT_W-1:0]   pattern_out;
    logic               done;

    always #4 clk = ~clk;

    seq_pattern_player #(.TICKS_PER_US(T)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .go           (go),
        .blk_count    (blk_count),
        .step_we      (step_we),
        .step_addr    (step_addr),
        .step_time    (step_time),
        .step_pattern (step_pattern),
        .blk_we       (blk_we),
        .blk_addr     (blk_addr),
        .blk_len      (blk_len),
        .blk_reps     (blk_reps),
        .pattern_out  (pattern_out),
        .done         (done)
    );

    int          n_chk = 0;
    int          n_err = 0;
    bit          finished = 1'b0;
    int          m_time [64];
    logic [31:0] m_pat  [64];
    int          m_len  [16];
    int          m_rep  [16];
    logic [31:0] held = '0;
    int          ev_k [$];
    logic [31:0] ev_p [$];
    int          done_k;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr_step(int a, int t, logic [31:0] p);
        @(negedge clk);
        step_we = 1'b1; step_addr = STEP_AW'(a); step_time = TIME_W'(t); step_pattern = p;
        @(negedge clk);
        step_we = 1'b0;
        m_time[a] = t; m_pat[a] = p;
    endtask

    task automatic wr_blk(int a, int len, int rep);
        @(negedge clk);
        blk_we = 1'b1; blk_addr = BLK_AW'(a); blk_len = LEN_W'(len); blk_reps = REP_W'(rep);
        @(negedge clk);
        blk_we = 1'b0;
        m_len[a] = len; m_rep[a] = rep;
    endtask

    // Event timeline from the requirements: cycle k is the clock period after the k-th edge
    // counted from the edge that samples go (k=1 right after it); boundaries at k = 2 + nT.
    task automatic build(int nblk);
        int c, base, k, r, s, f, x;
        ev_k.delete(); ev_p.delete();
        c = 1; base = 0; x = 0;
        for (int b = 0; b < nblk; b++) begin
            if (m_len[b] == 0 || m_rep[b] == 0) begin
                base += m_len[b];
                c++;
                continue;
            end
            k = c;
            while ((k % T) != (1 % T)) k++;
            r = k + 1;
            for (int p = 0; p < m_rep[b]; p++) begin
                s = 0;
                for (int j = 0; j < m_len[b]; j++) begin
                    f = (m_time[base + j] > s) ? m_time[base + j] : s;
                    x = r + f * T;
                    ev_k.push_back(x + 1);
                    ev_p.push_back(m_pat[base + j]);
                    s = f + 1;
                end
                if (p < m_rep[b] - 1) r = x + T;
                else c = x + 1;
            end
            base += m_len[b];
        end
        done_k = c + 1;
    endtask

    task automatic play(string tag, int nblk, int poke_k);
        build(nblk);
        @(negedge clk);
        go = 1'b1; blk_count = BCNT_W'(nblk);
        @(posedge clk);
        for (int k = 1; k <= done_k + 3; k++) begin
            @(negedge clk);
            if (k == 1) go = 1'b0;
            while (ev_k.size() > 0 && ev_k[0] <= k) begin
                held = ev_p[0];
                void'(ev_k.pop_front());
                void'(ev_p.pop_front());
            end
            chk(tag, $sformatf("pattern_out cycle %0d", k), pattern_out, held);
            chk(tag, $sformatf("done cycle %0d", k), {31'b0, done}, {31'b0, (k >= done_k)});
            if (k == poke_k) begin
                // R8: strike both tables and pulse go mid-run
                step_we = 1'b1; step_addr = '0; step_time = '0; step_pattern = 32'hFFFF_FFFF;
                blk_we = 1'b1; blk_addr = '0; blk_len = LEN_W'(1); blk_reps = REP_W'(9);
                go = 1'b1; blk_count = '0;
            end
            if (k == poke_k + 1) begin
                step_we = 1'b0; blk_we = 1'b0; go = 1'b0; blk_count = BCNT_W'(nblk);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "pattern_out in reset", pattern_out, '0);
        chk("R1", "done in reset", {31'b0, done}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pattern_out after reset", pattern_out, '0);
        chk("R1", "done after reset", {31'b0, done}, '0);

        // R3, R4: single block, equal and late step times
        wr_step(0, 0, 32'hA5A5_0001);
        wr_step(1, 3, 32'h0000_0002);
        wr_step(2, 3, 32'h0000_0003);
        wr_step(3, 10, 32'h8000_0004);
        wr_blk(0, 4, 1);
        repeat (10) @(negedge clk);
        chk("R2", "pattern_out idle after writes", pattern_out, '0);
        chk("R2", "done idle after writes", {31'b0, done}, '0);
        play("R3,R4", 1, 0);

        // R5, R6: repeats, skipped entries, contiguous segments
        wr_step(0, 1, 32'h0000_0011);
        wr_step(1, 2, 32'h0000_0012);
        wr_step(2, 0, 32'hDEAD_0021);
        wr_step(3, 0, 32'hDEAD_0022);
        wr_step(4, 0, 32'hDEAD_0023);
        wr_step(5, 0, 32'h0000_0051);
        wr_step(6, 0, 32'h0000_0052);
        wr_step(7, 5, 32'h0000_0071);
        wr_blk(0, 2, 3);
        wr_blk(1, 3, 0);
        wr_blk(2, 2, 2);
        wr_blk(3, 0, 5);
        wr_blk(4, 1, 1);
        repeat (4) @(negedge clk);
        chk("R7", "done held before new go", {31'b0, done}, 32'd1);
        chk("R2", "pattern held across idle writes", pattern_out, 32'h8000_0004);
        play("R5,R6,R8", 5, 20);

        // R8 at the ports: replay shows the mid-run writes had no effect; R7 go clears done
        play("R7,R8", 5, 0);

        // R7: empty block list finishes at once and keeps the word
        play("R7", 0, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule